// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block follows a singly linked chain of frame descriptors held in a word-addressed memory. The host places descriptors in memory, marks each one as handed over, and pulses a start input with the word address of the first descriptor. Each descriptor has a header of two words and then a run of fragment entries. Each fragment entry holds a byte count and a buffer address. The walker reads the header, then reads the fragment entries one at a time. For every entry it raises a single request to a data-move engine and waits for that engine's completion strobe. When the frame is finished, it writes a completion status back into the descriptor and moves on to the next one through the forward pointer.

The walk ends in one of three ways. A zero forward pointer ends it. A descriptor that the host has not handed over ends it. A host stop request ends it cleanly once the current descriptor has been retired. The walker reports start, stop and end-of-chain as single-cycle events. A configuration input selects single-fragment mode, in which each descriptor is taken to carry exactly one fragment entry.

The memory port has a fixed read latency of one cycle. Read data is presented the cycle after the read strobe.

Top module: `dwalk_chain`

## Requirements
- R1: After reset the block is idle. Busy, the transfer request, both memory strobes and all three events are low.
- R2: Descriptor layout, in word offsets from the descriptor address. Offset 0 holds the forward pointer. Offset 1 holds the status in bits 15:0 and the frame size in bits 31:16. Fragment entry k has its count word at offset 2+2k and its address word at offset 3+2k. Each transfer request carries that address, the length from count bits 30:0, and the last flag from count bit 31.
- R3: Transfer requests are issued strictly in entry and descriptor order. At most one is outstanding at a time. A request stays asserted with stable address and length until the done strobe, and it drops in the following cycle.
- R4: Retiring a descriptor rewrites offset 1. The size half is unchanged. Status bits 13:12 are cleared, bit 14 (frame complete) is set, and every other status bit, including bit 9, is kept.
- R5: A zero forward pointer in the retired descriptor sets status bit 11 in that write-back. The walk ends with a one-cycle end-of-chain event and busy low.
- R6: A fetched descriptor whose status bits 13:12 are not both 1 ends the walk. No transfer is issued, no memory is written, and an end-of-chain event is raised.
- R7: If ten entries are transferred without a last flag, the frame is retired with status bit 10 (error) set. No eleventh entry is fetched.
- R8: With single-fragment mode set, only entry 0 of each descriptor is used. Its transfer is flagged last whatever its count bit 31 says, and the error bit stays clear.
- R9: A stop pulse while busy lets the current descriptor finish and be written back. The walk then ends with a one-cycle stop event and without fetching the next descriptor. A stop pulse while idle has no effect on the next walk.
- R10: A go pulse while idle starts a walk at the supplied head address, with a one-cycle start event. A go pulse while busy is ignored.
- R11: When a walk ends at a descriptor that is not ready, that descriptor is left untouched. The descriptor retired before it does not get status bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, accepted only when idle |
| stop | input | 1 | Stop pulse, acted on at the next descriptor boundary |
| head_addr | input | AW | Word address of the first descriptor |
| one_frag | input | 1 | Single-fragment mode select |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after the read strobe |
| xfer_req | output | 1 | Fragment transfer request |
| xfer_addr | output | 32 | Fragment buffer address |
| xfer_len | output | 31 | Fragment byte length |
| xfer_last | output | 1 | This fragment closes the frame |
| xfer_done | input | 1 | Move engine completion strobe |
| busy | output | 1 | A walk is in progress |
| evt_start | output | 1 | One-cycle pulse: walk started |
| evt_stop | output | 1 | One-cycle pulse: walk halted by stop |
| evt_eoc | output | 1 | One-cycle pulse: walk reached end of chain |

## Verification
A wrong fragment index or address offset shows up on the very next transfer request as a wrong buffer address or length. A corrupted forward pointer shows up as a request for a descriptor that should never be fetched. A fault in the status merge stays hidden until the write-back of that descriptor. The bench therefore reads the descriptor words back after every walk. A stop or end flag held in the wrong state changes which event fires at the end of the walk and how many descriptors are retired. Each directed scenario compares the exact event counts and the write-back words as soon as busy falls.

// File: rtl/dwalk_pkg.sv
package dwalk_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  // status half-word codes
  localparam logic [HALF_W-1:0] ST_OWN_MASK = 16'h3000;
  localparam logic [HALF_W-1:0] ST_DONE     = 16'h4000;
  localparam logic [HALF_W-1:0] ST_EOC      = 16'h0800;
  localparam logic [HALF_W-1:0] ST_ERR      = 16'h0400;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR0, S_HDR1, S_STAT, S_CNT, S_ADRRD, S_ADRCAP, S_XFER, S_WB
  } walk_state_t;

  typedef enum logic [1:0] {A_FPTR, A_STAT, A_CNT, A_ADR} addr_kind_t;

  // descriptor handed to the engine only when both ownership bits are set
  function automatic logic owned_by_engine(input logic [HALF_W-1:0] st);
    return (st & ST_OWN_MASK) == ST_OWN_MASK;
  endfunction

  // word offset of a fragment entry word (second=0: count, second=1: address)
  function automatic int unsigned pair_offset(input int unsigned idx, input logic second);
    return 32'd2 + 32'd2 * idx + {31'd0, second};
  endfunction

  function automatic logic [WORD_W-2:0] frag_len(input logic [WORD_W-1:0] c);
    return c[WORD_W-2:0];
  endfunction

  function automatic logic frag_last(input logic [WORD_W-1:0] c);
    return c[WORD_W-1];
  endfunction

  // write-back word for offset 1 of a retired descriptor
  function automatic logic [WORD_W-1:0] retire_word(input logic [HALF_W-1:0] st,
                                                    input logic [HALF_W-1:0] sz,
                                                    input logic err,
                                                    input logic eoc);
    logic [HALF_W-1:0] ns;
    ns = (st & ~ST_OWN_MASK) | ST_DONE;
    if (err) ns = ns | ST_ERR;
    if (eoc) ns = ns | ST_EOC;
    return {sz, ns};
  endfunction

endpackage

// File: rtl/dwalk_addr.sv
module dwalk_addr
  import dwalk_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 4
) (
  input  logic [AW-1:0] base,
  input  addr_kind_t    kind,
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] cnt_off;
  logic [AW-1:0] adr_off;

  assign cnt_off = AW'(pair_offset(32'(idx), 1'b0));
  assign adr_off = AW'(pair_offset(32'(idx), 1'b1));

  always_comb begin
    case (kind)
      A_FPTR:  addr = base;
      A_STAT:  addr = base + AW'(1);
      A_CNT:   addr = base + cnt_off;
      A_ADR:   addr = base + adr_off;
      default: addr = base;
    endcase
  end

endmodule

// File: rtl/dwalk_frag.sv
module dwalk_frag
  import dwalk_pkg::*;
#(
  parameter int MAX_FRAGS = 10,
  parameter int IW        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic              one_frag,
  input  logic [WORD_W-1:0] cnt_word,
  output logic [IW-1:0]     idx,
  output logic              ends_frame,
  output logic              cap_hit
);

  localparam logic [IW-1:0] LAST_IDX = IW'(MAX_FRAGS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= idx + IW'(1);
  end

  // single-fragment mode closes the frame on entry 0
  assign ends_frame = frag_last(cnt_word) | one_frag;
  assign cap_hit    = (idx == LAST_IDX);

endmodule

// File: rtl/dwalk_retire.sv
module dwalk_retire
  import dwalk_pkg::*;
(
  input  logic [HALF_W-1:0] stat,
  input  logic [HALF_W-1:0] size,
  input  logic              err,
  input  logic              eoc,
  output logic [WORD_W-1:0] wdata
);

  assign wdata = retire_word(stat, size, err, eoc);

endmodule

// File: rtl/dwalk_ctrl.sv
module dwalk_ctrl
  import dwalk_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              stop,
  input  logic [AW-1:0]     head_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              xfer_done,
  input  logic              ends_frame,
  input  logic              cap_hit,
  output walk_state_t       state,
  output addr_kind_t        kind,
  output logic [AW-1:0]     cur,
  output logic              frag_clr,
  output logic              frag_adv,
  output logic              chain_end,
  output logic [HALF_W-1:0] stat,
  output logic [HALF_W-1:0] size,
  output logic              err,
  output logic [WORD_W-1:0] cnt,
  output logic [WORD_W-1:0] fadr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic              xfer_req,
  output logic              busy,
  output logic              evt_start,
  output logic              evt_stop,
  output logic              evt_eoc
);

  logic [WORD_W-1:0] fptr;
  logic              stop_pend;
  logic              xfer_fin;

  assign busy      = (state != S_IDLE);
  assign mem_rd_en = (state == S_HDR0) || (state == S_HDR1) ||
                     (state == S_CNT)  || (state == S_ADRRD);
  assign mem_wr_en = (state == S_WB);
  assign xfer_req  = (state == S_XFER);
  assign xfer_fin  = xfer_req && xfer_done;
  assign chain_end = (fptr == '0);
  assign frag_clr  = (state == S_STAT);
  assign frag_adv  = xfer_fin && !ends_frame && !cap_hit;

  always_comb begin
    case (state)
      S_HDR0:  kind = A_FPTR;
      S_HDR1:  kind = A_STAT;
      S_CNT:   kind = A_CNT;
      S_ADRRD: kind = A_ADR;
      S_WB:    kind = A_STAT;
      default: kind = A_FPTR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur       <= '0;
      fptr      <= '0;
      stat      <= '0;
      size      <= '0;
      err       <= 1'b0;
      cnt       <= '0;
      fadr      <= '0;
      stop_pend <= 1'b0;
      evt_start <= 1'b0;
      evt_stop  <= 1'b0;
      evt_eoc   <= 1'b0;
    end else begin
      evt_start <= 1'b0;
      evt_stop  <= 1'b0;
      evt_eoc   <= 1'b0;
      if (stop && state != S_IDLE) stop_pend <= 1'b1;
      case (state)
        S_IDLE: begin
          if (go) begin
            cur       <= head_addr;
            stop_pend <= 1'b0;
            evt_start <= 1'b1;
            state     <= S_HDR0;
          end
        end
        S_HDR0: state <= S_HDR1;
        S_HDR1: begin
          fptr  <= mem_rdata;
          state <= S_STAT;
        end
        S_STAT: begin
          stat <= mem_rdata[HALF_W-1:0];
          size <= mem_rdata[WORD_W-1:HALF_W];
          err  <= 1'b0;
          if (owned_by_engine(mem_rdata[HALF_W-1:0])) begin
            state <= S_CNT;
          end else begin
            evt_eoc <= 1'b1;
            state   <= S_IDLE;
          end
        end
        S_CNT: state <= S_ADRRD;
        S_ADRRD: begin
          cnt   <= mem_rdata;
          state <= S_ADRCAP;
        end
        S_ADRCAP: begin
          fadr  <= mem_rdata;
          state <= S_XFER;
        end
        S_XFER: begin
          if (xfer_done) begin
            if (ends_frame) begin
              state <= S_WB;
            end else if (cap_hit) begin
              err   <= 1'b1;
              state <= S_WB;
            end else begin
              state <= S_CNT;
            end
          end
        end
        S_WB: begin
          if (chain_end) begin
            evt_eoc <= 1'b1;
            state   <= S_IDLE;
          end else if (stop_pend || stop) begin
            evt_stop <= 1'b1;
            state    <= S_IDLE;
          end else begin
            cur   <= fptr[AW-1:0];
            state <= S_HDR0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dwalk_chain.sv
module dwalk_chain
  import dwalk_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MAX_FRAGS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              stop,
  input  logic [AW-1:0]     head_addr,
  input  logic              one_frag,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_req,
  output logic [31:0]       xfer_addr,
  output logic [30:0]       xfer_len,
  output logic              xfer_last,
  input  logic              xfer_done,
  output logic              busy,
  output logic              evt_start,
  output logic              evt_stop,
  output logic              evt_eoc
);

  localparam int IW = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1;

  walk_state_t       state;
  addr_kind_t        kind;
  logic [AW-1:0]     cur;
  logic              frag_clr;
  logic              frag_adv;
  logic              chain_end;
  logic [HALF_W-1:0] stat;
  logic [HALF_W-1:0] size;
  logic              err;
  logic [WORD_W-1:0] cnt;
  logic [WORD_W-1:0] fadr;
  logic [IW-1:0]     frag_idx;
  logic              ends_frame;
  logic              cap_hit;

  dwalk_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .stop       (stop),
    .head_addr  (head_addr),
    .mem_rdata  (mem_rdata),
    .xfer_done  (xfer_done),
    .ends_frame (ends_frame),
    .cap_hit    (cap_hit),
    .state      (state),
    .kind       (kind),
    .cur        (cur),
    .frag_clr   (frag_clr),
    .frag_adv   (frag_adv),
    .chain_end  (chain_end),
    .stat       (stat),
    .size       (size),
    .err        (err),
    .cnt        (cnt),
    .fadr       (fadr),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .xfer_req   (xfer_req),
    .busy       (busy),
    .evt_start  (evt_start),
    .evt_stop   (evt_stop),
    .evt_eoc    (evt_eoc)
  );

  dwalk_frag #(.MAX_FRAGS(MAX_FRAGS), .IW(IW)) u_frag (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (frag_clr),
    .adv        (frag_adv),
    .one_frag   (one_frag),
    .cnt_word   (cnt),
    .idx        (frag_idx),
    .ends_frame (ends_frame),
    .cap_hit    (cap_hit)
  );

  dwalk_addr #(.AW(AW), .IW(IW)) u_addr (
    .base (cur),
    .kind (kind),
    .idx  (frag_idx),
    .addr (mem_addr)
  );

  dwalk_retire u_retire (
    .stat  (stat),
    .size  (size),
    .err   (err),
    .eoc   (chain_end),
    .wdata (mem_wdata)
  );

  assign xfer_addr = fadr;
  assign xfer_len  = frag_len(cnt);
  assign xfer_last = ends_frame;

endmodule

// File: rtl/dwalk_chain_chk.sv
module dwalk_chain_chk #(
  parameter int AW        = 16,
  parameter int MAX_FRAGS = 10,
  parameter int IW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          one_frag,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [31:0]   mem_wdata,
  input logic          xfer_req,
  input logic [31:0]   xfer_addr,
  input logic [30:0]   xfer_len,
  input logic          xfer_last,
  input logic          xfer_done,
  input logic          busy,
  input logic          evt_start,
  input logic          evt_stop,
  input logic          evt_eoc,
  input logic [IW-1:0] frag_idx
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!xfer_req && !mem_rd_en && !mem_wr_en)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len))); // R3

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_done) |=> !xfer_req); // R3

  AST_XFER_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !(mem_rd_en || mem_wr_en)); // R3

  AST_RETIRE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_wdata[14] && mem_wdata[13:12] == 2'b00)); // R4

  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_eoc || evt_stop) |-> !busy); // R5

  AST_FRAG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (32'(frag_idx) < MAX_FRAGS)); // R7

  AST_ONE_FRAG: assert property (@(posedge clk) disable iff (!rst_n)
    (one_frag && xfer_req) |-> (xfer_last && frag_idx == '0)); // R8

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_start, evt_stop, evt_eoc})); // R9

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |-> busy); // R10

endmodule

bind dwalk_chain dwalk_chain_chk #(.AW(AW), .MAX_FRAGS(MAX_FRAGS), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .one_frag  (one_frag),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .mem_wdata (mem_wdata),
  .xfer_req  (xfer_req),
  .xfer_addr (xfer_addr),
  .xfer_len  (xfer_len),
  .xfer_last (xfer_last),
  .xfer_done (xfer_done),
  .busy      (busy),
  .evt_start (evt_start),
  .evt_stop  (evt_stop),
  .evt_eoc   (evt_eoc),
  .frag_idx  (frag_idx)
);

// File: tb/dwalk_chain_bench.sv
module dwalk_chain_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic        stop = 1'b0;
  logic [15:0] head_addr = '0;
  logic        one_frag = 1'b0;
  logic        mem_rd_en, mem_wr_en;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        xfer_req;
  logic [31:0] xfer_addr;
  logic [30:0] xfer_len;
  logic        xfer_last;
  logic        xfer_done = 1'b0;
  logic        busy, evt_start, evt_stop, evt_eoc;

  always #2.5 clk = ~clk;

  dwalk_chain u_dwalk_chain (
    .clk(clk), .rst_n(rst_n), .go(go), .stop(stop), .head_addr(head_addr),
    .one_frag(one_frag), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_last(xfer_last), .xfer_done(xfer_done), .busy(busy),
    .evt_start(evt_start), .evt_stop(evt_stop), .evt_eoc(evt_eoc)
  );

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
  end

  int n_chk = 0;
  int n_err = 0;
  int n_start = 0, n_stop = 0, n_eoc = 0;
  int log_n = 0;
  int lat = 1;
  int wait_cnt = 0;
  logic [31:0] lg_addr [0:31];
  logic [30:0] lg_len  [0:31];
  logic        lg_last [0:31];

  always @(negedge clk) begin
    if (evt_start) n_start++;
    if (evt_stop)  n_stop++;
    if (evt_eoc)   n_eoc++;
  end

  // move engine model: completes each request after lat cycles
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_done) begin
        xfer_done = 1'b0;
      end else if (xfer_req) begin
        wait_cnt++;
        if (wait_cnt >= lat) begin
          if (log_n < 32) begin
            lg_addr[log_n] = xfer_addr;
            lg_len[log_n]  = xfer_len;
            lg_last[log_n] = xfer_last;
          end
          log_n++;
          xfer_done = 1'b1;
          wait_cnt  = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  // start a walk; optional stop/go pulses at cycle offsets (-1 = none)
  task automatic run_walk(input logic [15:0] head, input logic one,
                          input int stop_at, input int go_at);
    one_frag = one;
    n_start = 0; n_stop = 0; n_eoc = 0; log_n = 0;
    @(negedge clk);
    head_addr = head; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (!busy) break;
      stop = (c == stop_at);
      go   = (c == go_at);
      if (c == go_at) head_addr = 16'h00F0;
      @(negedge clk);
    end
    stop = 1'b0; go = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 req", xfer_req, 0);
    chk("R1 strobes", {mem_rd_en, mem_wr_en}, 0);
    chk("R1 events", {evt_start, evt_stop, evt_eoc}, 0);
  endtask

  task automatic t_basic();
    clear_mem();
    lat = 3;
    mem[8'h10] = 32'h30; mem[8'h11] = {16'd100, 16'h3200};
    mem[8'h12] = 32'd40;           mem[8'h13] = 32'h1000;
    mem[8'h14] = 32'h8000_003C;    mem[8'h15] = 32'h2000;
    mem[8'h30] = 32'h0;  mem[8'h31] = {16'd77, 16'h3000};
    mem[8'h32] = 32'h8000_004D;    mem[8'h33] = 32'h3000;
    mem[8'hF1] = {16'd1, 16'h3000}; mem[8'hF2] = 32'h8000_0001;
    run_walk(16'h0010, 1'b0, -1, 4);
    chk("R3 transfer count", log_n, 3);
    chk("R2 frag0 addr", lg_addr[0], 32'h1000);
    chk("R2 frag0 len", lg_len[0], 40);
    chk("R2 frag0 last", lg_last[0], 0);
    chk("R2 frag1 addr", lg_addr[1], 32'h2000);
    chk("R2 frag1 len/last", {lg_len[1], lg_last[1]}, {31'd60, 1'b1});
    chk("R3 second descriptor frag", {lg_addr[2], lg_len[2]}, {32'h3000, 31'd77});
    chk("R4 retire word", mem[8'h11], {16'd100, 16'h4200});
    chk("R5 last retire word", mem[8'h31], {16'd77, 16'h4800});
    chk("R5 eoc events", n_eoc, 1);
    chk("R10 start events", n_start, 1);
    chk("R10 busy go ignored", mem[8'hF1], {16'd1, 16'h3000});
    chk("R5 idle after", busy, 0);
  endtask

  task automatic t_not_ready();
    clear_mem();
    lat = 1;
    mem[8'h40] = 32'h0; mem[8'h41] = {16'd5, 16'h1000};
    mem[8'h42] = 32'h8000_0008; mem[8'h43] = 32'h7000;
    run_walk(16'h0040, 1'b0, -1, -1);
    chk("R6 no transfer", log_n, 0);
    chk("R6 descriptor untouched", mem[8'h41], {16'd5, 16'h1000});
    chk("R6 eoc event", n_eoc, 1);
  endtask

  task automatic t_cap();
    clear_mem();
    lat = 1;
    mem[8'h50] = 32'h0; mem[8'h51] = {16'd200, 16'h3000};
    for (int i = 0; i < 11; i++) begin
      mem[8'h52 + 2*i] = (i == 10) ? 32'h8000_0063 : 32'(i + 1);
      mem[8'h53 + 2*i] = 32'h100 * i;
    end
    run_walk(16'h0050, 1'b0, -1, -1);
    chk("R7 ten transfers", log_n, 10);
    chk("R7 tenth fragment", {lg_addr[9], lg_len[9]}, {32'h900, 31'd10});
    chk("R7 error retire", mem[8'h51], {16'd200, 16'h4C00});
  endtask

  task automatic t_one_frag();
    clear_mem();
    lat = 2;
    mem[8'h80] = 32'h0; mem[8'h81] = {16'd64, 16'h3000};
    mem[8'h82] = 32'd64;        mem[8'h83] = 32'h4000;
    mem[8'h84] = 32'h8000_0001; mem[8'h85] = 32'h5000;
    run_walk(16'h0080, 1'b1, -1, -1);
    chk("R8 single transfer", log_n, 1);
    chk("R8 forced last", {lg_addr[0], lg_len[0], lg_last[0]}, {32'h4000, 31'd64, 1'b1});
    chk("R8 no error", mem[8'h81], {16'd64, 16'h4800});
  endtask

  task automatic t_stop();
    clear_mem();
    lat = 2;
    mem[8'h90] = 32'hA0; mem[8'h91] = {16'd11, 16'h3000};
    mem[8'h92] = 32'h8000_000B; mem[8'h93] = 32'h9000;
    mem[8'hA0] = 32'hB0; mem[8'hA1] = {16'd12, 16'h3000};
    mem[8'hA2] = 32'h8000_000C; mem[8'hA3] = 32'hA000;
    mem[8'hB0] = 32'h0;  mem[8'hB1] = {16'd13, 16'h3000};
    mem[8'hB2] = 32'h8000_000D; mem[8'hB3] = 32'hB000;
    run_walk(16'h0090, 1'b0, 2, -1);
    chk("R9 one descriptor", log_n, 1);
    chk("R9 current retired", mem[8'h91], {16'd11, 16'h4000});
    chk("R9 next untouched", mem[8'hA1], {16'd12, 16'h3000});
    chk("R9 stop/eoc events", {n_stop, n_eoc}, {32'd1, 32'd0});
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    run_walk(16'h00A0, 1'b0, -1, -1);
    chk("R9 idle stop ignored", log_n, 2);
    chk("R9 idle stop events", {n_stop, n_eoc}, {32'd0, 32'd1});
    chk("R5 chain tail retired", mem[8'hB1], {16'd13, 16'h4800});
  endtask

  task automatic t_mid_not_ready();
    clear_mem();
    lat = 1;
    mem[8'hC0] = 32'hD0; mem[8'hC1] = {16'd21, 16'h3000};
    mem[8'hC2] = 32'h8000_0015; mem[8'hC3] = 32'hC000;
    mem[8'hD0] = 32'h0;  mem[8'hD1] = {16'd22, 16'h2000};
    run_walk(16'h00C0, 1'b0, -1, -1);
    chk("R11 one transfer", log_n, 1);
    chk("R11 prior no eoc bit", mem[8'hC1], {16'd21, 16'h4000});
    chk("R11 stalled untouched", mem[8'hD1], {16'd22, 16'h2000});
    chk("R11 eoc event", n_eoc, 1);
  endtask

  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_not_ready();
    t_cap();
    t_one_frag();
    t_stop();
    t_mid_not_ready();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule